// File: doc/BRIEF.md
# Byte-Merge Partial Write Path

This block stands between a system-side write source and a memory that stores each 64-bit word together with eight checkbits. A write request carries an address, a full data word and one enable bit per byte lane. Because the checkbits protect the whole word, they cannot be fixed up for a single byte. When any lane is disabled, the block therefore fetches the stored word, takes each byte from either the new data or the old data, computes fresh checkbits over the composite word and writes the word and checkbits back in one access. When every lane is enabled, the read is skipped.

The memory side has two ports. One is a read port, where the returned data is valid in the same cycle as the read handshake. The other is a write port that carries the data and checkbits together. Both ports use a valid/ready handshake. The block takes the returned data as already corrected. It holds exactly one request at a time.

Top module: `bytemerge_wr`

## Requirements
- R1: While reset is asserted (rst_n low) and directly after it, req_ready is 1 and mem_rd_valid and mem_wr_valid are 0.
- R2: req_ready is 1 only when no request is in flight. After a request is accepted (req_valid and req_ready both 1 on a clock edge), no other request is accepted until the write handshake (mem_wr_valid and mem_wr_ready both 1) has completed.
- R3: A request with at least one req_be bit 0 raises mem_rd_valid in the cycle after acceptance, with mem_rd_addr equal to the accepted address. Exactly one read is issued before the write.
- R4: A request with all req_be bits 1 issues no read. mem_wr_valid rises in the second cycle after acceptance.
- R5: Byte lane i of the written word (bits 8i+7 to 8i) is the request's lane i when req_be[i] is 1. When req_be[i] is 0, it is lane i of the word read from memory.
- R6: The checkbit code works as follows. Data bit j occupies code position p_j, where p_j is the (j+1)-th integer of 3 or more that is not a power of two. Raw bit k, for k from 0 to 6, is the XOR of the data bits whose p_j has bit k set. Raw bit 7 is the XOR of all 64 data bits and raw bits 0 to 6. mem_wr_chk is the raw value with bits 2 and 3 inverted.
- R7: A written word of all zeros carries checkbits 0x0C.
- R8: mem_wr_addr equals the accepted address. Address, data and checkbits stay constant while mem_wr_valid is 1 and mem_wr_ready is 0.
- R9: mem_rdata is taken only in the cycle of the read handshake. Data shown while mem_rd_ready is 0 has no effect on the written word. mem_rd_addr stays constant while mem_rd_valid waits for mem_rd_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Word address of the write |
| req_data | input | 64 | New data word |
| req_be | input | 8 | Lane enables, 1 takes the new byte |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_ready | input | 1 | Memory completes read; data valid this cycle |
| mem_rd_addr | output | 16 | Read address |
| mem_rdata | input | 64 | Stored word returned by the read |
| mem_wr_valid | output | 1 | Write request to memory |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 16 | Write address |
| mem_wr_data | output | 64 | Composite word to store |
| mem_wr_chk | output | 8 | Checkbits for the composite word |

## Verification
Suppose the controller state is wrong. Within one cycle, req_ready, mem_rd_valid or mem_wr_valid would disagree with the reference model. A skipped or extra read would appear as a read strobe where none is due, or as a missing one. A wrong captured lane, a wrong lane select, or read data latched outside the handshake stays hidden until the write is issued, two cycles after the read handshake. There it shows up in mem_wr_data and, in almost every case, in mem_wr_chk. The bench feeds inverted data whenever mem_rd_ready is low, so a capture on the wrong cycle corrupts the written word. The merged result is also fed back through later partial writes to the same addresses, so a lane error carries into the following writes.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

   localparam int MAX_DW = 256;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_MERGE = 2'd2,
      ST_WRITE = 2'd3
   } bmw_state_e;

   // Coverage mask of one Hamming checkbit over a dw-bit data word.
   // Data bit j sits at the j-th position >= 3 that is not a power of two.
   function automatic logic [MAX_DW-1:0] cov_mask(int k, int dw);
      logic [MAX_DW-1:0] m;
      int p;
      m = '0;
      p = 2;
      for (int j = 0; j < dw; j++) begin
         do p++; while ((p & (p - 1)) == 0);
         m[j] = ((p >> k) & 1) == 1;
      end
      return m;
   endfunction

endpackage

// File: rtl/bmw_ctrl.sv
module bmw_ctrl
   import bmw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_fire,
   input  logic       be_full,
   input  logic       rd_fire,
   input  logic       wr_fire,
   output bmw_state_e state_q
);

   bmw_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_fire) state_d = be_full ? ST_MERGE : ST_READ;
         ST_READ:  if (rd_fire)  state_d = ST_MERGE;
         ST_MERGE: state_d = ST_WRITE;
         ST_WRITE: if (wr_fire)  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/bmw_lane_mux.sv
module bmw_lane_mux #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic [DATA_W-1:0] sys_word,
   input  logic [DATA_W-1:0] mem_word,
   input  logic [LANES-1:0]  lane_sel,
   output logic [DATA_W-1:0] merged
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] =
         lane_sel[l] ? sys_word[l*LANE_W +: LANE_W] : mem_word[l*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/bmw_ckgen.sv
module bmw_ckgen
   import bmw_pkg::*;
#(
   parameter int               DATA_W  = 64,
   parameter int               CHK_W   = 8,
   parameter logic [CHK_W-1:0] CHK_INV = 8'h0C,
   localparam int              HAM_W   = CHK_W - 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   logic [HAM_W-1:0] ham;
   logic             overall;

   for (genvar k = 0; k < HAM_W; k++) begin : g_ham
      localparam logic [MAX_DW-1:0] FULL_MASK = cov_mask(k, DATA_W);
      localparam logic [DATA_W-1:0] MASK      = FULL_MASK[DATA_W-1:0];
      assign ham[k] = ^(data & MASK);
   end

   assign overall = (^data) ^ (^ham);
   assign chk     = {overall, ham} ^ CHK_INV;

endmodule

// File: rtl/bytemerge_wr.sv
module bytemerge_wr
   import bmw_pkg::*;
#(
   parameter int               ADDR_W  = 16,
   parameter int               DATA_W  = 64,
   parameter int               LANE_W  = 8,
   parameter int               CHK_W   = 8,
   parameter logic [CHK_W-1:0] CHK_INV = 8'h0C,
   localparam int              LANES   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [LANES-1:0]  req_be,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic [CHK_W-1:0]  mem_wr_chk
);

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (DATA_W > MAX_DW) begin : g_bad_width
      $error("DATA_W exceeds MAX_DW");
   end
   if ((1 << (CHK_W - 1)) < DATA_W + CHK_W) begin : g_bad_chk
      $error("CHK_W too small for SEC-DED over DATA_W");
   end

   bmw_state_e        state_q;
   logic              req_fire, rd_fire, wr_fire, be_full;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] sys_q, old_q, wdata_q, merged;
   logic [LANES-1:0]  be_q;
   logic [CHK_W-1:0]  wchk_q, chk_d;

   assign req_ready    = (state_q == ST_IDLE);
   assign mem_rd_valid = (state_q == ST_READ);
   assign mem_wr_valid = (state_q == ST_WRITE);
   assign req_fire     = req_valid && req_ready;
   assign rd_fire      = mem_rd_valid && mem_rd_ready;
   assign wr_fire      = mem_wr_valid && mem_wr_ready;
   assign be_full      = &req_be;

   bmw_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .be_full  (be_full),
      .rd_fire  (rd_fire),
      .wr_fire  (wr_fire),
      .state_q  (state_q)
   );

   bmw_lane_mux #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mux (
      .sys_word (sys_q),
      .mem_word (old_q),
      .lane_sel (be_q),
      .merged   (merged)
   );

   bmw_ckgen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CHK_INV(CHK_INV)) u_ck (
      .data (merged),
      .chk  (chk_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         sys_q   <= '0;
         be_q    <= '0;
         old_q   <= '0;
         wdata_q <= '0;
         wchk_q  <= '0;
      end else begin
         if (req_fire) begin
            addr_q <= req_addr;
            sys_q  <= req_data;
            be_q   <= req_be;
         end
         if (rd_fire) old_q <= mem_rdata;
         if (state_q == ST_MERGE) begin
            wdata_q <= merged;
            wchk_q  <= chk_d;
         end
      end
   end

   assign mem_rd_addr = addr_q;
   assign mem_wr_addr = addr_q;
   assign mem_wr_data = wdata_q;
   assign mem_wr_chk  = wchk_q;

endmodule

// File: rtl/bmw_chk.sv
module bmw_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int LANES  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [LANES-1:0]  req_be,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [DATA_W-1:0] mem_wr_data,
   input logic [CHK_W-1:0]  mem_wr_chk
);

   p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid || mem_wr_valid) |-> !req_ready);

   p_one_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_valid && mem_wr_valid));

   p_partial_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !(&req_be)) |=>
         (mem_rd_valid && mem_rd_addr == $past(req_addr)));

   p_full_skips_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (&req_be)) |=> !mem_rd_valid);

   p_zero_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && mem_wr_data == '0) |-> mem_wr_chk == CHK_W'(8'h0C));

   p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_chk)));

   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

endmodule

bind bytemerge_wr bmw_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CHK_W  (CHK_W),
   .LANES  (LANES)
) u_bmw_chk (.*);

// File: tb/bytemerge_wr_tb.sv
module bytemerge_wr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic [63:0] req_data = '0;
   logic [7:0]  req_be = '0;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [15:0] mem_rd_addr;
   logic [63:0] mem_rdata = '0;
   logic        mem_wr_valid;
   logic        mem_wr_ready = 1'b0;
   logic [15:0] mem_wr_addr;
   logic [63:0] mem_wr_data;
   logic [7:0]  mem_wr_chk;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bytemerge_wr dut_i (.*);

   // Reference model state
   int          m_phase = 0;
   int          m_reads = 0;
   logic [15:0] m_addr;
   logic [63:0] m_data, m_old, m_wdata;
   logic [7:0]  m_be, m_wchk;
   logic [63:0] mem [16];
   logic [31:0] lfsr = 32'hACE1_2357;
   bit          tight = 1'b0;

   function automatic logic [7:0] ref_code(logic [63:0] d);
      logic [6:0] h = '0;
      int p = 2;
      for (int j = 0; j < 64; j++) begin
         p++;
         while ((p & (p - 1)) == 0) p++;
         for (int k = 0; k < 7; k++) if (((p >> k) & 1) == 1) h[k] ^= d[j];
      end
      return {(^d) ^ (^h), h} ^ 8'h0C;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Model step on each rising edge, from bench-driven inputs only
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0;
      end else begin
         case (m_phase)
            0: if (req_valid) begin
                  m_addr = req_addr; m_data = req_data; m_be = req_be; m_reads = 0;
                  m_phase = (req_be == 8'hFF) ? 2 : 1;
               end
            1: if (mem_rd_ready) begin
                  m_old = mem[m_addr[3:0]]; m_reads++; m_phase = 2;
               end
            2: begin
                  for (int l = 0; l < 8; l++)
                     m_wdata[l*8 +: 8] = m_be[l] ? m_data[l*8 +: 8] : m_old[l*8 +: 8];
                  m_wchk = ref_code(m_wdata);
                  m_phase = 3;
               end
            default: if (mem_wr_ready) begin
                  mem[m_addr[3:0]] = m_wdata; m_phase = 0;
               end
         endcase
      end
   end

   // Compare every cycle, then drive memory responses
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", req_ready, m_phase == 0);
         chk("R3", mem_rd_valid, m_phase == 1);
         chk("R8", mem_wr_valid, m_phase == 3);
         if (m_phase == 1) chk("R3,R9 rd_addr", mem_rd_addr, m_addr);
         if (m_phase == 3) begin
            chk("R8 addr", mem_wr_addr, m_addr);
            chk("R5,R9 data", mem_wr_data, m_wdata);
            chk("R6 chk", mem_wr_chk, m_wchk);
            if (m_be == 8'hFF) chk("R4 no read", m_reads, 0);
            else               chk("R3 one read", m_reads, 1);
            if (m_wdata == 64'd0) chk("R7 zero code", mem_wr_chk, 8'h0C);
         end
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mem_rd_ready = tight | lfsr[3];
      mem_wr_ready = tight | lfsr[7];
      // Inverted data whenever the read is not being completed
      mem_rdata = mem_rd_ready ? mem[m_addr[3:0]] : ~mem[m_addr[3:0]];
   end

   task automatic send(logic [15:0] a, logic [63:0] d, logic [7:0] be);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
      while (m_phase != 0) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_data = ~d;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'h1111_1111_1111_1111 * i);
      repeat (3) @(negedge clk);
      chk("R1 ready", req_ready, 1'b1);
      chk("R1 rd", mem_rd_valid, 1'b0);
      chk("R1 wr", mem_wr_valid, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      chk("R1 ready after", req_ready, 1'b1);
      chk("R1 wr after", mem_wr_valid, 1'b0);
      chk("R7 direct", ref_code(64'd0), 8'h0C);
      tight = 1'b1;
      send(16'h0000, 64'd0, 8'hFF);
      send(16'h0001, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
      send(16'h0001, 64'hA5A5_A5A5_A5A5_A5A5, 8'h01);
      tight = 1'b0;
      send(16'h0002, 64'h1122_3344_5566_7788, 8'h80);
      send(16'h0002, 64'hDEAD_BEEF_CAFE_F00D, 8'hAA);
      send(16'h0003, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F);
      send(16'h0003, 64'h0, 8'hFF);
      send(16'h0003, 64'h0, 8'h00);
      for (int n = 0; n < 60; n++)
         send({12'h0, lfsr[11:8]}, {lfsr, ~lfsr}, lfsr[23:16]);
      while (m_phase != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule